// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block forms the data for the four partial-word access instructions of a big-endian-style 32-bit core: load-left, load-right, store-left and store-right. Each access names an effective address. The two low bits of that address select a byte offset. The memory side always works on the aligned word, which is the effective address with its two low bits cleared.

For a load, the block merges the aligned memory word into the current value of the destination register. The result is the new register value. For a store, the block merges the register value into the aligned memory word. The result is the word to write back. The offset selects how many bytes come from each side, and from which end.

The block computes its result in one pass of combinational logic. The result, the aligned address and two write enables are then held in one output register stage with a synchronous active-high reset. The memory read, load-delay handling and any endianness switch sit outside the block.

Top module: `uwm_merge_top`

## Requirements
- R1: One cycle after an accepted request (`req_valid` high), `rsp_addr` equals `req_ea` with bits [1:0] forced to zero, and `rsp_valid` is high.
- R2: Load-left is opcode 2'b00. With offset k = `req_ea[1:0]`, the result is (mem << 8*(3-k)) | (reg & mask), where mask is 0x00FFFFFF, 0x0000FFFF, 0x000000FF or 0 for k = 0, 1, 2, 3. At k = 3 the result is the whole memory word.
- R3: Load-right is opcode 2'b01. The result is (mem >> 8*k) | (reg & mask), where mask is 0, 0xFF000000, 0xFFFF0000 or 0xFFFFFF00 for k = 0..3. At k = 0 the result is the whole memory word.
- R4: Store-left is opcode 2'b10. The write-back word is (reg >> 8*(3-k)) | (mem & mask), where mask is 0xFFFFFF00, 0xFFFF0000, 0xFF000000 or 0 for k = 0..3. At k = 3 it is the whole register word.
- R5: Store-right is opcode 2'b11. The write-back word is (reg << 8*k) | (mem & mask), where mask is 0, 0x000000FF, 0x0000FFFF or 0x00FFFFFF for k = 0..3. At k = 0 it is the whole register word.
- R6: A load whose destination index `req_dest` is 0 gives `rsp_reg_we` low. Its `rsp_data` equals the unchanged `req_reg` value, for every offset and both load kinds.
- R7: A load to a nonzero destination gives `rsp_reg_we` high and `rsp_mem_we` low. A store gives `rsp_mem_we` high and `rsp_reg_we` low, whatever `req_dest` holds. The two enables are never high together.
- R8: While `rst` is high, and in the cycle after it falls, `rsp_valid`, `rsp_reg_we`, `rsp_mem_we`, `rsp_addr` and `rsp_data` are all zero.
- R9: One cycle after a cycle with `req_valid` low, `rsp_valid`, `rsp_reg_we` and `rsp_mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| req_ea | input | 32 | Effective byte address |
| req_dest | input | 5 | Destination register index (loads) |
| req_reg | input | 32 | Current register value |
| req_mem | input | 32 | Aligned memory word |
| rsp_valid | output | 1 | Registered result valid |
| rsp_addr | output | 32 | Aligned address |
| rsp_data | output | 32 | New register value (load) or write-back word (store) |
| rsp_reg_we | output | 1 | Register write enable |
| rsp_mem_we | output | 1 | Memory write enable |

## Verification
Two actions can apply to the same request. The register-zero suppression can land on a load whose offset selects a full or partial merge. A store can arrive with a destination index of zero, which must not affect its memory write. The bench sends loads to register 0 at every offset, mixed back-to-back with stores that carry a zero index and with idle cycles. Each registered result is judged against a byte-placement reference, one cycle after the request.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MOP_LD_LEFT  = 2'b00,
        MOP_LD_RIGHT = 2'b01,
        MOP_ST_LEFT  = 2'b10,
        MOP_ST_RIGHT = 2'b11
    } merge_op_e;

    function automatic logic op_is_load(input merge_op_e op);
        return (op == MOP_LD_LEFT) || (op == MOP_LD_RIGHT);
    endfunction

    function automatic logic op_is_left(input merge_op_e op);
        return (op == MOP_LD_LEFT) || (op == MOP_ST_LEFT);
    endfunction

endpackage

// File: rtl/uwm_lane_ctl.sv
module uwm_lane_ctl
    import uwm_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES)
) (
    input  merge_op_e              op,
    input  logic [OFS_W-1:0]       ofs,
    output logic [LANES-1:0]       take_new,
    output logic [LANES-1:0][OFS_W-1:0] src_idx
);
    localparam int TOP = LANES - 1;

    // Lane 0 is the least significant byte. The rules differ by
    // direction (left/right) and by whether memory or register is new.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            int k;
            k = int'(ofs);
            take_new[i] = 1'b0;
            src_idx[i]  = '0;
            unique case (op)
                MOP_LD_LEFT: begin
                    take_new[i] = (i >= TOP - k);
                    src_idx[i]  = OFS_W'(i - (TOP - k));
                end
                MOP_LD_RIGHT: begin
                    take_new[i] = (i <= TOP - k);
                    src_idx[i]  = OFS_W'(i + k);
                end
                MOP_ST_LEFT: begin
                    take_new[i] = (i <= k);
                    src_idx[i]  = OFS_W'(i + (TOP - k));
                end
                MOP_ST_RIGHT: begin
                    take_new[i] = (i >= k);
                    src_idx[i]  = OFS_W'(i - k);
                end
                default: begin
                    take_new[i] = 1'b0;
                    src_idx[i]  = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/uwm_lane_mux.sv
module uwm_lane_mux
    import uwm_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES),
    localparam int DW    = LANES * BYTE_W
) (
    input  logic [LANES-1:0]            take_new,
    input  logic [LANES-1:0][OFS_W-1:0] src_idx,
    input  logic [DW-1:0]               new_word,
    input  logic [DW-1:0]               keep_word,
    output logic [DW-1:0]               merged
);
    logic [LANES-1:0][BYTE_W-1:0] new_b;
    logic [LANES-1:0][BYTE_W-1:0] keep_b;
    logic [LANES-1:0][BYTE_W-1:0] out_b;

    assign new_b  = new_word;
    assign keep_b = keep_word;

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign out_b[i] = take_new[i] ? new_b[src_idx[i]] : keep_b[i];
    end

    assign merged = out_b;

endmodule

// File: rtl/uwm_merge_top.sv
module uwm_merge_top
    import uwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    parameter int REG_IDX_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              req_op,
    input  logic [ADDR_W-1:0]       req_ea,
    input  logic [REG_IDX_W-1:0]    req_dest,
    input  logic [LANES*8-1:0]      req_reg,
    input  logic [LANES*8-1:0]      req_mem,
    output logic                    rsp_valid,
    output logic [ADDR_W-1:0]       rsp_addr,
    output logic [LANES*8-1:0]      rsp_data,
    output logic                    rsp_reg_we,
    output logic                    rsp_mem_we
);
    localparam int OFS_W = $clog2(LANES);
    localparam int DW    = LANES * BYTE_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic              reg_we;
        logic              mem_we;
    } merge_rsp_t;

    merge_op_e               op;
    logic [OFS_W-1:0]        ofs;
    logic                    is_load;
    logic                    dest_zero;
    logic [LANES-1:0]        take_new;
    logic [LANES-1:0][OFS_W-1:0] src_idx;
    logic [DW-1:0]           new_word;
    logic [DW-1:0]           keep_word;
    logic [DW-1:0]           merged;
    merge_rsp_t              nxt;
    merge_rsp_t              cur;

    assign op        = merge_op_e'(req_op);
    assign ofs       = req_ea[OFS_W-1:0];
    assign is_load   = op_is_load(op);
    assign dest_zero = (req_dest == '0);
    assign new_word  = is_load ? req_mem : req_reg;
    assign keep_word = is_load ? req_reg : req_mem;

    uwm_lane_ctl #(.LANES(LANES)) u_ctl (
        .op       (op),
        .ofs      (ofs),
        .take_new (take_new),
        .src_idx  (src_idx)
    );

    uwm_lane_mux #(.LANES(LANES)) u_mux (
        .take_new  (take_new),
        .src_idx   (src_idx),
        .new_word  (new_word),
        .keep_word (keep_word),
        .merged    (merged)
    );

    always_comb begin
        nxt.valid  = req_valid;
        nxt.addr   = {req_ea[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        nxt.data   = (is_load && dest_zero) ? req_reg : merged;
        nxt.reg_we = req_valid && is_load && !dest_zero;
        nxt.mem_we = req_valid && !is_load;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign rsp_valid  = cur.valid;
    assign rsp_addr   = cur.addr;
    assign rsp_data   = cur.data;
    assign rsp_reg_we = cur.reg_we;
    assign rsp_mem_we = cur.mem_we;

endmodule

// File: rtl/uwm_merge_chk.sv
module uwm_merge_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_op,
    input logic [31:0] req_ea,
    input logic [4:0]  req_dest,
    input logic [31:0] req_reg,
    input logic [31:0] req_mem,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic [31:0] rsp_data,
    input logic        rsp_reg_we,
    input logic        rsp_mem_we
);
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid && rsp_addr == {$past(req_ea[31:2]), 2'b00}); // R1
    AST_LL_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b00 && req_ea[1:0] == 2'd3 && req_dest != 5'd0)
        |=> rsp_data == $past(req_mem)); // R2
    AST_LR_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b01 && req_ea[1:0] == 2'd0 && req_dest != 5'd0)
        |=> rsp_data == $past(req_mem)); // R3
    AST_SL_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10 && req_ea[1:0] == 2'd3)
        |=> rsp_data == $past(req_reg)); // R4
    AST_SR_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11 && req_ea[1:0] == 2'd0)
        |=> rsp_data == $past(req_reg)); // R5
    AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op[1] && req_dest == 5'd0)
        |=> !rsp_reg_we && rsp_data == $past(req_reg)); // R6
    AST_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_reg_we && rsp_mem_we)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_reg_we && !rsp_mem_we); // R9
endmodule

bind uwm_merge_top uwm_merge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_ea     (req_ea),
    .req_dest   (req_dest),
    .req_reg    (req_reg),
    .req_mem    (req_mem),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_data   (rsp_data),
    .rsp_reg_we (rsp_reg_we),
    .rsp_mem_we (rsp_mem_we)
);

// File: tb/sim_uwm_merge_top.sv
module sim_uwm_merge_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_ea = '0;
    logic [4:0]  req_dest = '0;
    logic [31:0] req_reg = '0;
    logic [31:0] req_mem = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [31:0] rsp_data;
    logic        rsp_reg_we;
    logic        rsp_mem_we;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 8 ns period

    uwm_merge_top u0 (.*);

    // Byte-placement reference: walks the source bytes and drops each
    // into its destination lane, starting from the word that is kept.
    function automatic logic [31:0] ref_merge(input logic [1:0] op, input int k,
                                              input logic [31:0] r, input logic [31:0] m);
        logic [31:0] res;
        case (op)
            2'b00: begin res = r; for (int j = 0; j <= k; j++) res[8*(j+3-k) +: 8] = m[8*j +: 8]; end
            2'b01: begin res = r; for (int j = k; j <= 3; j++) res[8*(j-k) +: 8] = m[8*j +: 8]; end
            2'b10: begin res = m; for (int j = 3-k; j <= 3; j++) res[8*(j-3+k) +: 8] = r[8*j +: 8]; end
            default: begin res = m; for (int j = 0; j <= 3-k; j++) res[8*(j+k) +: 8] = r[8*j +: 8]; end
        endcase
        return res;
    endfunction

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, judge at the next falling edge.
    task automatic issue(input bit v, input logic [1:0] op, input logic [31:0] ea,
                         input logic [4:0] dst, input logic [31:0] r, input logic [31:0] m);
        logic [31:0] exp_data;
        bit ld;
        ld = !op[1];
        req_valid = v; req_op = op; req_ea = ea; req_dest = dst; req_reg = r; req_mem = m;
        if (ld && dst == 0) exp_data = r;
        else                exp_data = ref_merge(op, int'(ea[1:0]), r, m);
        @(negedge clk);
        if (v) begin
            check("R1", {32'd0, rsp_addr}, {32'd0, ea & 32'hFFFF_FFFC});
            check("R1", {63'd0, rsp_valid}, 64'd1);
            if (ld && dst == 0) check("R6", {32'd0, rsp_data}, {32'd0, exp_data});
            else                check(tag_of(op), {32'd0, rsp_data}, {32'd0, exp_data});
            if (ld && dst == 0) check("R6", {63'd0, rsp_reg_we}, 64'd0);
            else                check("R7", {62'd0, rsp_reg_we, rsp_mem_we}, ld ? 64'd2 : 64'd1);
        end else begin
            check("R9", {61'd0, rsp_valid, rsp_reg_we, rsp_mem_we}, 64'd0);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats_r [4];
        logic [31:0] pats_m [4];
        pats_r[0] = 32'hAABB_CCDD; pats_m[0] = 32'h1122_3344;
        pats_r[1] = 32'hFFFF_FFFF; pats_m[1] = 32'h0000_0000;
        pats_r[2] = 32'h0000_0000; pats_m[2] = 32'hFFFF_FFFF;
        pats_r[3] = 32'h8001_7E5A; pats_m[3] = 32'hC3A5_0F96;

        @(negedge clk);
        check("R8", {29'd0, rsp_valid, rsp_reg_we, rsp_mem_we, rsp_data}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", {rsp_addr, rsp_data}, 64'd0);
        check("R8", {61'd0, rsp_valid, rsp_reg_we, rsp_mem_we}, 64'd0);

        // every variant, every offset, several data patterns, varied upper address
        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 4; k++)
                    issue(1'b1, 2'(o), 32'h1000_0040 + 32'(p * 32'h0101_0100) + 32'(k),
                          5'd9 + 5'(p), pats_r[p], pats_m[p]);

        // register-zero loads at every offset, interleaved with zero-index stores and idle cycles
        for (int k = 0; k < 4; k++) begin
            issue(1'b1, 2'b00, 32'h2000_0000 + 32'(k), 5'd0, 32'h5566_7788, 32'h99AA_BBCC);
            issue(1'b1, 2'b10, 32'h2000_0010 + 32'(k), 5'd0, 32'h5566_7788, 32'h99AA_BBCC);
            issue(1'b1, 2'b01, 32'h2000_0020 + 32'(k), 5'd0, 32'hDEAD_BEEF, 32'h0123_4567);
            issue(1'b0, 2'b11, 32'h2000_0030 + 32'(k), 5'd3, 32'hDEAD_BEEF, 32'h0123_4567);
            issue(1'b1, 2'b11, 32'h2000_0040 + 32'(k), 5'd0, 32'hDEAD_BEEF, 32'h0123_4567);
        end

        // idle cycles with changing inputs
        issue(1'b0, 2'b00, 32'hFFFF_FFFF, 5'd31, 32'h1, 32'h2);
        issue(1'b0, 2'b10, 32'h0000_0003, 5'd1, 32'h3, 32'h4);
        issue(1'b1, 2'b00, 32'hFFFF_FFFF, 5'd31, 32'h0102_0304, 32'hA0B0_C0D0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule